// File: doc/BRIEF.md
# Background and Sprite Pixel Priority Mixer

This block merges one tile background layer and one sprite layer into a single stream of colour-RAM indices, one pixel per clock. Upstream fetch logic supplies two things. The first is a 16-entry circular background buffer that holds two 8-pixel columns. The second is a 16-pixel window of the sprite line buffer that starts at the current column. The mixer selects the right entry from each. The background position takes the fine horizontal scroll into account. The sprite position can be moved 8 pixels further along by a mode bit. The mixer then resolves priority and produces a 5-bit index: palette bit on top of a 4-bit colour.

Sprites always draw from the upper 16-entry palette. A background pixel flagged as high priority hides a sprite only when its own colour is nonzero. The backdrop register fills every pixel where both layers are transparent. It also fills every pixel of the first column when that column is masked, and every pixel while the display is off.

Top module: `pix_mixer`

## Requirements
- R1: A pixel is accepted on a clock edge where `pixValid` is high. Its index appears on `cramIdx` with `cramValid` high after exactly one edge. After an edge where `pixValid` is low, `cramValid` is low and `cramIdx` keeps its previous value.
- R2: A background entry has this layout: bits 3:0 colour, bit 4 palette, bit 5 priority. If the selected background entry has its priority bit set and a nonzero colour, the output is {palette, colour} of that entry, whatever the sprite pixel is.
- R3: Otherwise, a nonzero selected sprite pixel (4 bits) wins, and the output is 0x10 plus its colour.
- R4: Otherwise, a nonzero background colour is output as {palette, colour}, with its own palette bit.
- R5: If both the background colour and the sprite pixel are zero, the output is 0x10 | `backdrop`. This also holds when the background priority bit is set. A priority entry with colour zero does not hide a nonzero sprite.
- R6: When `col0Mask` is high and `colIdx` is 0, every pixel of that column is 0x10 | `backdrop`.
- R7: The sprite pixel is window entry `pixIdx` when `sprShift` is low, and entry `pixIdx`+8 when it is high. Entry j occupies `sprWin[4j+3:4j]`.
- R8: The background entry read is ((`colIdx` bit 0)·8 + (`hScroll` & 7) + `pixIdx`) mod 16. Entry k occupies `bgBuf[6k+5:6k]`.
- R9: While `displayEn` is low, every accepted pixel is 0x10 | `backdrop`.
- R10: After reset, `cramValid` is 0 and `cramIdx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel accepted on this edge |
| colIdx | input | 5 | Current 8-pixel column |
| pixIdx | input | 3 | Pixel within the column |
| bgBuf | input | 96 | 16 background entries of 6 bits |
| sprWin | input | 64 | 16 sprite line-buffer pixels of 4 bits, from column start |
| backdrop | input | 4 | Backdrop colour register |
| hScroll | input | 8 | Horizontal scroll value |
| col0Mask | input | 1 | Blank column 0 to backdrop |
| sprShift | input | 1 | Read sprites 8 pixels further along |
| displayEn | input | 1 | Display enable |
| cramIdx | output | 5 | Colour-RAM index |
| cramValid | output | 1 | cramIdx holds a new pixel |

## Verification
Every result of this block is due one clock edge after the inputs that produced it: the priority decision, the scroll and shift selection, the masking, and the valid flag all pass through the single output register. The bench drives a new pixel on each falling edge. On the next falling edge it compares the outputs with the value its behavioural model predicted for the previous inputs. The model also keeps the last index, so that held output is checked after gaps in `pixValid`. Each compare is tagged with the rule that decided that pixel.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int COLOR_W   = 4;
  localparam int IDX_W     = COLOR_W + 1;
  localparam int ENT_W     = COLOR_W + 2;
  localparam int BUF_DEPTH = 16;
  localparam int POS_W     = $clog2(BUF_DEPTH);
  localparam int PIX_W     = 3;
  localparam int COL_W     = 5;

  typedef struct packed {
    logic             forceBackdrop;
    logic [POS_W-1:0] bgPos;
    logic [POS_W-1:0] sprPos;
  } mix_strobe_t;
endpackage

// File: rtl/mix_ctrl.sv
module mix_ctrl
  import mix_pkg::*;
(
  input  logic [COL_W-1:0] colIdx,
  input  logic [PIX_W-1:0] pixIdx,
  input  logic [7:0]       hScroll,
  input  logic             col0Mask,
  input  logic             sprShift,
  input  logic             displayEn,
  output mix_strobe_t      strobe
);
  logic [POS_W-1:0] colBase;
  logic [POS_W-1:0] fineScroll;

  always_comb begin
    colBase    = {colIdx[0], {PIX_W{1'b0}}};
    fineScroll = POS_W'(hScroll[PIX_W-1:0]);
    strobe.forceBackdrop = !displayEn || (col0Mask && (colIdx == '0));
    strobe.bgPos  = colBase + fineScroll + POS_W'(pixIdx);
    strobe.sprPos = {sprShift, pixIdx};
  end
endmodule

// File: rtl/mix_datapath.sv
module mix_datapath
  import mix_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pixValid,
  input  mix_strobe_t                strobe,
  input  logic [BUF_DEPTH*ENT_W-1:0] bgBuf,
  input  logic [BUF_DEPTH*COLOR_W-1:0] sprWin,
  input  logic [COLOR_W-1:0]         backdrop,
  output logic [IDX_W-1:0]           cramIdx,
  output logic                       cramValid
);
  logic [ENT_W-1:0]   bgArr  [BUF_DEPTH];
  logic [COLOR_W-1:0] sprArr [BUF_DEPTH];

  for (genvar k = 0; k < BUF_DEPTH; k++) begin : g_unpack
    assign bgArr[k]  = bgBuf[k*ENT_W +: ENT_W];
    assign sprArr[k] = sprWin[k*COLOR_W +: COLOR_W];
  end

  logic [ENT_W-1:0]   bgEnt;
  logic [COLOR_W-1:0] bgColor;
  logic               bgPal;
  logic               bgPrio;
  logic [COLOR_W-1:0] sprPix;
  logic [IDX_W-1:0]   mixIdx;

  always_comb begin
    bgEnt   = bgArr[strobe.bgPos];
    bgColor = bgEnt[COLOR_W-1:0];
    bgPal   = bgEnt[COLOR_W];
    bgPrio  = bgEnt[COLOR_W+1];
    sprPix  = sprArr[strobe.sprPos];
    if (strobe.forceBackdrop)
      mixIdx = {1'b1, backdrop};
    else if (bgPrio && (bgColor != '0))
      mixIdx = {bgPal, bgColor};
    else if (sprPix != '0)
      mixIdx = {1'b1, sprPix};
    else if (bgColor != '0)
      mixIdx = {bgPal, bgColor};
    else
      mixIdx = {1'b1, backdrop};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cramIdx   <= '0;
      cramValid <= 1'b0;
    end else begin
      cramValid <= pixValid;
      if (pixValid) cramIdx <= mixIdx;
    end
  end
endmodule

// File: rtl/pix_mixer.sv
module pix_mixer
  import mix_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pixValid,
  input  logic [4:0]   colIdx,
  input  logic [2:0]   pixIdx,
  input  logic [95:0]  bgBuf,
  input  logic [63:0]  sprWin,
  input  logic [3:0]   backdrop,
  input  logic [7:0]   hScroll,
  input  logic         col0Mask,
  input  logic         sprShift,
  input  logic         displayEn,
  output logic [4:0]   cramIdx,
  output logic         cramValid
);
  mix_strobe_t strobe;

  mix_ctrl i_ctrl (
    .colIdx(colIdx), .pixIdx(pixIdx), .hScroll(hScroll),
    .col0Mask(col0Mask), .sprShift(sprShift), .displayEn(displayEn),
    .strobe(strobe)
  );

  mix_datapath i_dp (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .strobe(strobe),
    .bgBuf(bgBuf), .sprWin(sprWin), .backdrop(backdrop),
    .cramIdx(cramIdx), .cramValid(cramValid)
  );
endmodule

// File: rtl/pix_mixer_chk.sv
module pix_mixer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic [4:0] colIdx,
  input logic [3:0] backdrop,
  input logic       col0Mask,
  input logic       displayEn,
  input logic [4:0] cramIdx,
  input logic       cramValid
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> cramValid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> (!cramValid && $stable(cramIdx)));
  assert_blank_display_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !displayEn) |=> (cramIdx == {1'b1, $past(backdrop)}));
  assert_col0_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && col0Mask && colIdx == 5'd0) |=> (cramIdx == {1'b1, $past(backdrop)}));
  assert_reset_state_R10: assert property (@(posedge clk)
    $past(!rstN) |-> (!cramValid && cramIdx == 5'd0));
endmodule

bind pix_mixer pix_mixer_chk i_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .colIdx(colIdx),
  .backdrop(backdrop), .col0Mask(col0Mask), .displayEn(displayEn),
  .cramIdx(cramIdx), .cramValid(cramValid)
);

// File: tb/test_pix_mixer.sv
module test_pix_mixer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixValid = 1'b0;
  logic [4:0]  colIdx = '0;
  logic [2:0]  pixIdx = '0;
  logic [95:0] bgBuf = '0;
  logic [63:0] sprWin = '0;
  logic [3:0]  backdrop = '0;
  logic [7:0]  hScroll = '0;
  logic        col0Mask = 1'b0;
  logic        sprShift = 1'b0;
  logic        displayEn = 1'b1;
  logic [4:0]  cramIdx;
  logic        cramValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int    expIdx = 0;
  bit    expValid = 0;
  string expTag = "R10";

  always #2.5 clk = ~clk;

  pix_mixer i_pix_mixer (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .colIdx(colIdx),
    .pixIdx(pixIdx), .bgBuf(bgBuf), .sprWin(sprWin), .backdrop(backdrop),
    .hScroll(hScroll), .col0Mask(col0Mask), .sprShift(sprShift),
    .displayEn(displayEn), .cramIdx(cramIdx), .cramValid(cramValid)
  );

  // model of the value decided for the inputs now on the pins
  task automatic predict();
    int pos, spos, e, c, pal, pr, s;
    if (!pixValid) begin
      expValid = 0;
      expTag = "R1";
      return;
    end
    expValid = 1;
    if (!displayEn) begin
      expIdx = 16 + backdrop; expTag = "R9"; return;
    end
    if (col0Mask && colIdx == 0) begin
      expIdx = 16 + backdrop; expTag = "R6"; return;
    end
    pos  = ((colIdx % 2) * 8 + (hScroll % 8) + pixIdx) % 16;
    spos = (sprShift ? 8 : 0) + pixIdx;
    e    = bgBuf[6*pos +: 6];
    c    = e % 16;
    pal  = (e / 16) % 2;
    pr   = (e / 32) % 2;
    s    = sprWin[4*spos +: 4];
    if (pr == 1 && c != 0) begin
      expIdx = pal * 16 + c; expTag = "R2 R8";
    end else if (s != 0) begin
      expIdx = 16 + s; expTag = sprShift ? "R3 R7" : "R3";
    end else if (c != 0) begin
      expIdx = pal * 16 + c; expTag = "R4 R8";
    end else begin
      expIdx = 16 + backdrop; expTag = "R5";
    end
  endtask

  task automatic compare();
    checks++;
    if (cramValid !== expValid || cramIdx !== 5'(expIdx)) begin
      fails++;
      $display("FAIL %s: valid=%0b idx=0x%0h expected valid=%0b idx=0x%0h",
               expTag, cramValid, cramIdx, expValid, expIdx);
    end
  endtask

  // one pixel: drive at falling edge, check at the next falling edge
  task automatic step(input bit v, input int col, input int pix);
    pixValid = v; colIdx = 5'(col); pixIdx = 3'(pix);
    predict();
    @(negedge clk);
    compare();
  endtask

  task automatic setBg(input int k, input int prio, input int pal, input int col);
    bgBuf[6*k +: 6] = 6'(prio * 32 + pal * 16 + col);
  endtask

  task automatic setSpr(input int j, input int col);
    sprWin[4*j +: 4] = 4'(col);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    expValid = 0; expIdx = 0; expTag = "R10";
    compare();
    rstN = 1'b1;
    @(negedge clk);
    backdrop = 4'h7;

    // R2: priority opaque background beats sprite
    setBg(0, 1, 0, 5); setSpr(0, 9);
    step(1, 2, 0);
    // R5: priority with colour zero does not beat sprite (sprite wins, R3)
    setBg(1, 1, 1, 0); setSpr(1, 3);
    step(1, 2, 1);
    // R4: plain background with palette 1 vs transparent sprite
    setBg(2, 0, 1, 6); setSpr(2, 0);
    step(1, 2, 2);
    // R3: sprite over non-priority background
    setBg(3, 0, 0, 4); setSpr(3, 12);
    step(1, 2, 3);
    // R5: all transparent, priority bit set, colour zero
    setBg(4, 1, 0, 0); setSpr(4, 0);
    step(1, 2, 4);
    // R1: gap holds value
    step(0, 2, 5);
    step(0, 2, 5);
    // R8: scroll and odd column
    hScroll = 8'hFD; setBg(14, 0, 1, 11); setSpr(1, 0);
    step(1, 3, 1);    // pos = (8+5+1)%16 = 14
    hScroll = 8'h00;
    // R7: sprite shift selects upper half
    sprShift = 1'b1; setSpr(10, 8); setSpr(2, 0); setBg(2, 0, 0, 0);
    step(1, 4, 2);
    sprShift = 1'b0;
    // R6: column 0 masked
    col0Mask = 1'b1;
    step(1, 0, 0);
    step(1, 1, 0);
    col0Mask = 1'b0;
    // R9: display off
    displayEn = 1'b0; backdrop = 4'hA;
    step(1, 7, 3);
    displayEn = 1'b1;

    // broad sweep with random contents
    for (int n = 0; n < 3000; n++) begin
      if (n % 8 == 0) begin
        bgBuf = {$urandom, $urandom, $urandom};
        sprWin = {$urandom, $urandom};
        if ($urandom % 3 == 0) sprWin = '0;
        hScroll = 8'($urandom);
        backdrop = 4'($urandom);
        sprShift = 1'($urandom);
        col0Mask = 1'($urandom);
        displayEn = ($urandom % 10) != 0;
      end
      step(($urandom % 5) != 0, (n / 8) % 32, n % 8);
    end
    step(0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule